// File: doc/BRIEF.md
# Supply-Loss Write Guard and Processor Reset Sequencer

This block is the clocked sequencing logic of a battery-backed static memory controller. An external comparator reports whether the main supply is above its trip level. The block brings that flag into the clock domain and uses it to decide three things. It decides whether the host's active-low memory select and write strobes may reach the memory. It decides whether an open-drain processor reset line is pulled low. It decides whether the memory runs from the main supply or from the backup cell. The trip tolerance the comparator should use is chosen by a configuration pin that the block forwards to the comparator.

When the supply fails, the block blocks the memory strobes, asserts the reset pull-down and selects the battery within two clock cycles. This holds no matter what the host is doing at the time. When the supply returns, two independent hold timers start. The shorter one ends write protection and the longer one releases the processor reset. Both lengths are given in microseconds and turned into cycle counts from a clock-frequency parameter. If the supply drops again while either timer runs, both timers restart from zero. The block has no data stream, so every pin is a plain level with no valid/ready handshake and no back-pressure. A host strobe that is low when protection engages is cut off at once. After protection ends, a strobe that is already low is held off until the host drives it high at a clock edge.

Top module: `nvs_power_guard`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n` and `mem_we_n` are 1, `cpu_rst_pull` is 1 and `batt_sel` is 1, whatever `supply_ok_in` and the host strobes do.
- R2: `batt_sel` (1 = backup battery, 0 = main supply) equals the inverse of `supply_ok_in` as sampled two rising clock edges earlier.
- R3: Two clock edges after `supply_ok_in` is sampled low, `mem_ce_n` and `mem_we_n` are 1 and `cpu_rst_pull` is 1.
- R4: After the synchronized supply flag becomes 1, the memory strobes stay blocked until it has stayed 1 for `WP_CYC` further clock edges, where `WP_CYC` = `CLK_HZ` x `WP_HOLD_US` / 10^6.
- R5: After the synchronized supply flag becomes 1, `cpu_rst_pull` stays 1 until it has stayed 1 for `RST_CYC` further edges, where `RST_CYC` = `CLK_HZ` x `RST_HOLD_US` / 10^6. After that, `cpu_rst_pull` is 0.
- R6: A host strobe that is low when protection engages is forced high at once on its memory side. It is not held low until the host ends it.
- R7: After protection ends, each memory strobe follows its host strobe only once that host strobe has been sampled high at a rising edge while unprotected. The select and write strobes are armed independently.
- R8: If the synchronized flag drops while either hold timer runs, both timers restart from zero. The full hold lengths then apply again after the flag returns.
- R9: `cmp_tol_sel` equals `tol_sel_in` at all times (0 = 5 % trip level, 1 = 10 % trip level).
- R10: No memory strobe is ever low while `batt_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| supply_ok_in | input | 1 | Comparator flag: main supply above trip level (asynchronous) |
| tol_sel_in | input | 1 | Trip tolerance choice, 0 = 5 %, 1 = 10 % |
| host_ce_n | input | 1 | Host memory select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| mem_ce_n | output | 1 | Gated memory select to the memory array |
| mem_we_n | output | 1 | Gated write strobe to the memory array |
| cpu_rst_pull | output | 1 | Drive-low enable for the open-drain processor reset; 0 = released |
| batt_sel | output | 1 | Memory supply source, 1 = battery, 0 = main supply |
| cmp_tol_sel | output | 1 | Tolerance choice forwarded to the comparator |

## Verification
The assertions check on every cycle that a sampled supply loss blocks both strobes and asserts reset two edges later. They also check that no strobe is low on battery, that no memory strobe falls unless its host strobe is low, that reset never releases while on battery, and that the tolerance choice is forwarded. The exact hold lengths, the restart of both timers after a dropout at any point in their count, and the re-arming rule after release are shown only by the bench. The bench sweeps the dropout position across every cycle of the reset window and compares each output against cycle counts worked out from the two hold lengths.

// File: rtl/nvs_guard_pkg.sv
package nvs_guard_pkg;
  localparam int NUM_STROBES = 2;
  localparam int IDX_CE      = 0;
  localparam int IDX_WE      = 1;

  function automatic longint us_to_cycles(input longint hz, input longint us);
    return (hz * us) / 64'd1_000_000;
  endfunction
endpackage

// File: rtl/nvs_sync2.sv
module nvs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/nvs_hold_timer.sv
module nvs_hold_timer #(
  parameter longint LIMIT = 64'd100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  // Counts consecutive edges with run high; any low cycle restarts it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  // Gated by run so a dropout ends the hold without waiting a cycle.
  assign done = run && (cnt == LIM);
endmodule

// File: rtl/nvs_strobe_gate.sv
module nvs_strobe_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         protect,
  input  logic [N-1:0] host_n,
  output logic [N-1:0] mem_n
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic armed;

    // A lane arms only after its host strobe is seen high while unprotected.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed <= 1'b0;
      else if (protect)   armed <= 1'b0;
      else if (host_n[g]) armed <= 1'b1;
    end

    assign mem_n[g] = protect | ~armed | host_n[g];
  end
endmodule

// File: rtl/nvs_power_guard.sv
module nvs_power_guard #(
  parameter longint CLK_HZ      = 64'd125_000_000,
  parameter longint WP_HOLD_US  = 64'd125_000,
  parameter longint RST_HOLD_US = 64'd350_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_in,
  input  logic tol_sel_in,
  input  logic host_ce_n,
  input  logic host_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic cpu_rst_pull,
  output logic batt_sel,
  output logic cmp_tol_sel
);
  import nvs_guard_pkg::*;

  localparam longint WP_CYC  = us_to_cycles(CLK_HZ, WP_HOLD_US);
  localparam longint RST_CYC = us_to_cycles(CLK_HZ, RST_HOLD_US);

  logic                   supply_ok;
  logic                   wp_done;
  logic                   rst_done;
  logic [NUM_STROBES-1:0] host_vec;
  logic [NUM_STROBES-1:0] mem_vec;

  nvs_sync2 u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (supply_ok_in),
    .sync_out (supply_ok)
  );

  nvs_hold_timer #(.LIMIT(WP_CYC)) u_wp_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (supply_ok),
    .done  (wp_done)
  );

  nvs_hold_timer #(.LIMIT(RST_CYC)) u_rst_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (supply_ok),
    .done  (rst_done)
  );

  always_comb begin
    host_vec         = '1;
    host_vec[IDX_CE] = host_ce_n;
    host_vec[IDX_WE] = host_we_n;
  end

  nvs_strobe_gate #(.N(NUM_STROBES)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .protect (~wp_done),
    .host_n  (host_vec),
    .mem_n   (mem_vec)
  );

  assign mem_ce_n     = mem_vec[IDX_CE];
  assign mem_we_n     = mem_vec[IDX_WE];
  assign cpu_rst_pull = ~rst_done;
  assign batt_sel     = ~supply_ok;
  assign cmp_tol_sel  = tol_sel_in;
endmodule

// File: rtl/nvs_power_guard_chk.sv
module nvs_power_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok_in,
  input logic tol_sel_in,
  input logic host_ce_n,
  input logic host_we_n,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic cpu_rst_pull,
  input logic batt_sel,
  input logic cmp_tol_sel
);
  // R3: two sampled-low edges block both strobes on the next edge
  a_r3_loss_blocks_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok_in && !$past(supply_ok_in)) |=> (mem_ce_n && mem_we_n));

  // R3: the same loss asserts the reset pull-down and picks the battery
  a_r3_loss_asserts_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok_in && !$past(supply_ok_in)) |=> (cpu_rst_pull && batt_sel));

  // R10: no strobe reaches the memory while running on battery
  a_r10_no_strobe_on_batt: assert property (@(posedge clk) disable iff (!rst_n)
    batt_sel |-> (mem_ce_n && mem_we_n));

  // R6: a memory write strobe only falls while the host holds it low
  a_r6_we_follows_host: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !host_we_n);

  // R6: a memory select only falls while the host holds it low
  a_r6_ce_follows_host: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> !host_ce_n);

  // R5: reset is never released while on battery
  a_r5_release_on_mains: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_pull) |-> !batt_sel);

  // R9: tolerance choice reaches the comparator
  a_r9_tol_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_tol_sel == tol_sel_in);
endmodule

bind nvs_power_guard nvs_power_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok_in (supply_ok_in),
  .tol_sel_in   (tol_sel_in),
  .host_ce_n    (host_ce_n),
  .host_we_n    (host_we_n),
  .mem_ce_n     (mem_ce_n),
  .mem_we_n     (mem_we_n),
  .cpu_rst_pull (cpu_rst_pull),
  .batt_sel     (batt_sel),
  .cmp_tol_sel  (cmp_tol_sel)
);

// File: tb/nvs_power_guard_test.sv
module nvs_power_guard_test;
  localparam longint T_HZ  = 64'd1_000_000;
  localparam longint T_WP  = 64'd20;
  localparam longint T_RST = 64'd45;
  localparam int WP  = int'(T_WP);
  localparam int RST = int'(T_RST);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok_in = 1'b0;
  logic tol_sel_in = 1'b0;
  logic host_ce_n = 1'b1;
  logic host_we_n = 1'b1;
  logic mem_ce_n, mem_we_n, cpu_rst_pull, batt_sel, cmp_tol_sel;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  // Reference state: supply history, run length of synced flag, arm flags.
  bit h1 = 1'b0, h2 = 1'b0;
  int streak = 0;
  bit arm_ce = 1'b0, arm_we = 1'b0;

  always #4 clk = ~clk;

  nvs_power_guard #(.CLK_HZ(T_HZ), .WP_HOLD_US(T_WP), .RST_HOLD_US(T_RST)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok_in(supply_ok_in), .tol_sel_in(tol_sel_in),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .cpu_rst_pull(cpu_rst_pull), .batt_sel(batt_sel),
    .cmp_tol_sel(cmp_tol_sel)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle at a negedge: drive, check against the arithmetic model, advance.
  task automatic cyc(input bit sup, input bit tol, input bit ce, input bit we, input string req);
    bit sync_m, rel, rrel;
    supply_ok_in = sup; tol_sel_in = tol; host_ce_n = ce; host_we_n = we;
    #1;
    sync_m = h2;
    streak = sync_m ? streak + 1 : 0;
    rel  = (streak >= WP + 1);
    rrel = (streak >= RST + 1);
    chk("R2", "batt_sel", batt_sel, !sync_m);
    chk("R5", "cpu_rst_pull", cpu_rst_pull, !rrel);
    chk("R9", "cmp_tol_sel", cmp_tol_sel, tol);
    chk(req, "mem_ce_n", mem_ce_n, !(rel && arm_ce && !ce));
    chk(req, "mem_we_n", mem_we_n, !(rel && arm_we && !we));
    if (rel) begin arm_ce = arm_ce | ce; arm_we = arm_we | we; end
    else begin arm_ce = 1'b0; arm_we = 1'b0; end
    h2 = h1; h1 = sup;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset holds every output safe even with supply present and strobes low
    @(negedge clk);
    supply_ok_in = 1'b1; host_ce_n = 1'b0; host_we_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R1", "mem_ce_n", mem_ce_n, 1'b1);
      chk("R1", "mem_we_n", mem_we_n, 1'b1);
      chk("R1", "cpu_rst_pull", cpu_rst_pull, 1'b1);
      chk("R1", "batt_sel", batt_sel, 1'b1);
      @(negedge clk);
    end
    supply_ok_in = 1'b0;
    rst_n = 1'b1;

    // R4/R5: full power-up sweep with toggling strobes and both tolerances
    for (int k = 0; k < RST + 8; k++)
      cyc(1'b1, k[2], (k % 2) == 0, (k % 3) != 1, "R4");

    // R3/R6: strobes low and passing, then supply lost mid-strobe
    cyc(1'b1, 1'b0, 1'b1, 1'b1, "R3");
    for (int k = 0; k < 2; k++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 8; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6");

    // R7: strobes held low through power-up stay blocked until re-armed
    for (int k = 0; k < WP + 6; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, "R7");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R7");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    for (int k = 0; k < RST; k++) cyc(1'b1, 1'b0, 1'b1, 1'b1, "R7");

    // R8: one-cycle dropout at every offset of the hold windows
    for (int d = 0; d < RST + 4; d++) begin
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b1, 1'b1, "R8");
      for (int k = 0; k < d; k++) cyc(1'b1, 1'b0, (k % 2) == 0, 1'b1, "R8");
      cyc(1'b0, 1'b0, 1'b1, 1'b1, "R8");
      for (int k = 0; k < RST + 6; k++) cyc(1'b1, 1'b1, (k % 2) == 0, (k % 4) != 3, "R8");
    end

    // R10: battery mode never lets a write through, strobes active throughout
    for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R10");

    finish_run();
  end
endmodule